// File: doc/BRIEF.md
# Debug Vector Trap and Entry Cause Unit

This unit sits beside the instruction fetch stage and compares every valid fetch address against the seven exception vector locations. Each vector has its own arm bit. When a fetch hits an armed vector, the unit requests a debug exception. It does this without using any of the general breakpoint comparators. The request is raised one cycle after the fetch, so the core can tag that instruction and take the debug exception before the instruction executes.

The reset vector is handled differently from the other six. Its arm bit and the halt-mode bit are inputs that the debug transport holds. They are not state that this block clears, so they stay valid while reset is asserted. The first reset-vector fetch after reset is released traps whether or not the global enable is set.

Other debug event sources can fire in the same cycle: the instruction and data breakpoints, the trace-buffer-full break and the external request. The unit records only the most important of these in a 3-bit cause code. It also keeps a sticky flag for data aborts seen while the core is in its special debug state. Those aborts are recorded in the flag and are not raised as exceptions.

Top module: `dbg_vtrap_top`

## Requirements
- R1: Vector index i (bit i of `cfg_trap_en`) sits at offset 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18, 0x1C for i = 0..6 (reset, undefined, software interrupt, prefetch abort, data abort, IRQ, FIQ). The base is 0x00000000, or 0xFFFF0000 when `cfg_high_vec` is 1. Any other address, such as offset 0x14, never traps.
- R2: A hit on vector 1..6 requests debug (cause code 3) only when `cfg_global_en`, `cfg_halt_mode` and the vector's arm bit are all 1.
- R3: A hit on vector 0 requests debug with cause code 6 when `cfg_halt_mode` and `cfg_trap_en[0]` are both 1, whatever `cfg_global_en` holds.
- R4: `dbg_req` rises on the cycle after the qualifying fetch and lasts one cycle per fetch. A fetch with `fetch_valid` low never traps.
- R5: While `rst_n` is low (sampled synchronously), all outputs are 0 on the next cycle and fetches are ignored. The first reset-vector fetch after reset is released traps under R3.
- R6: When events coincide, the cause code is chosen in this order, highest first: reset vector trap 6, instruction breakpoint 1, data breakpoint 2, other vector trap 3, trace-buffer-full 4, external request 5. Any event raises `dbg_req`.
- R7: `dbg_cause` changes only on a cycle where `dbg_req` is raised. Otherwise it holds its value (0 after reset).
- R8: A data abort with `in_dbg_state` and `cfg_halt_mode` both 1 sets `sticky_abort` on the next cycle, and `dabort_exc` stays 0.
- R9: `sticky_abort` stays set until `sticky_clr` is pulsed. If a new setting abort arrives in the same cycle as the clear, the flag is set.
- R10: A data abort with `in_dbg_state` low raises `dabort_exc` on the next cycle and leaves `sticky_abort` unchanged.
- R11: With `cfg_halt_mode` low, a data abort in debug state does not set `sticky_abort` and raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_global_en | input | 1 | Global debug enable |
| cfg_halt_mode | input | 1 | Halt-mode debug selected |
| cfg_high_vec | input | 1 | Select high vector base 0xFFFF0000 |
| cfg_trap_en | input | 7 | Per-vector arm bits, bit i = vector i |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| dabort | input | 1 | Data abort detected |
| in_dbg_state | input | 1 | Core is in the special debug state |
| sticky_clr | input | 1 | Clear the sticky abort flag |
| evt_ibrk | input | 1 | Instruction breakpoint hit |
| evt_dbrk | input | 1 | Data breakpoint hit |
| evt_tbfull | input | 1 | Trace-buffer-full break |
| evt_ext | input | 1 | External debug request |
| dbg_req | output | 1 | Debug exception request |
| dbg_cause | output | 3 | Cause code of the latest request |
| sticky_abort | output | 1 | Data abort seen in debug state |
| dabort_exc | output | 1 | Data abort exception raised |

## Verification
The assertions assume the following about the inputs:
- The configuration bits are steady, or at least defined, in every cycle where reset is released.
- An asserted event or abort strobe lasts for exactly the cycle in which it should be counted.
- `fetch_addr` has a known value whenever `fetch_valid` is high.

The stimulus meets these assumptions. It changes every input only just after a falling edge and sets each strobe for a single cycle. It drives every configuration bit to a known value before reset is released. Reset is held for several cycles, so every `|=>` property starts from registers that are already settled.

// File: rtl/dbg_vtrap_pkg.sv
// Package: shared cause codes and vector layout for the vector trap unit.
// Assumes vector slots are word aligned below 0x20 from the selected base.
package dbg_vtrap_pkg;

    localparam int N_VEC = 7;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_IBRK    = 3'd1,
        CAUSE_DBRK    = 3'd2,
        CAUSE_VTRAP   = 3'd3,
        CAUSE_TBFULL  = 3'd4,
        CAUSE_EXT     = 3'd5,
        CAUSE_RSTTRAP = 3'd6
    } cause_e;

    // Offset of vector slot idx; slot 0x14 is reserved and skipped.
    function automatic logic [7:0] vec_offset(input int idx);
        int off;
        off = (idx < 5) ? idx * 4 : (idx + 1) * 4;
        return 8'(off);
    endfunction

endpackage

// File: rtl/dbg_vec_match.sv
// Module: compares one fetch address against every exception vector slot.
// Assumes the high base has its low byte clear so base plus offset is exact.
module dbg_vec_match
    import dbg_vtrap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              high_vec,
    output logic [N_VEC-1:0]  hit
);

    logic [ADDR_W-1:0] base;

    // Pick the low or high vector table base.
    always_comb base = high_vec ? HIGH_BASE : '0;

    for (genvar i = 0; i < N_VEC; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_OFF = ADDR_W'(vec_offset(i));
        // One equality comparator per vector slot.
        assign hit[i] = fetch_valid && (fetch_addr == (base + SLOT_OFF));
    end

endmodule

// File: rtl/dbg_cause_arb.sv
// Module: fixed-priority encoder over simultaneous debug events.
// Assumes all event inputs are single-cycle strobes from the same clock.
module dbg_cause_arb
    import dbg_vtrap_pkg::*;
(
    input  logic   rst_trap,
    input  logic   ibrk,
    input  logic   dbrk,
    input  logic   vtrap,
    input  logic   tbfull,
    input  logic   ext,
    output logic   any_evt,
    output cause_e cause
);

    // Any source present raises a request.
    always_comb any_evt = rst_trap | ibrk | dbrk | vtrap | tbfull | ext;

    // Highest-priority source wins the cause code.
    always_comb begin
        if (rst_trap)    cause = CAUSE_RSTTRAP;
        else if (ibrk)   cause = CAUSE_IBRK;
        else if (dbrk)   cause = CAUSE_DBRK;
        else if (vtrap)  cause = CAUSE_VTRAP;
        else if (tbfull) cause = CAUSE_TBFULL;
        else if (ext)    cause = CAUSE_EXT;
        else             cause = CAUSE_NONE;
    end

    // Guard: an instruction breakpoint beats everything below the reset trap.
    always_comb begin
        // R6
        if (ibrk && !rst_trap) begin
            ibrk_wins_chk: assert (cause == CAUSE_IBRK);
        end
    end

endmodule

// File: rtl/dbg_sticky_abort.sv
// Module: latches data aborts seen in debug state; forwards the rest.
// Assumes dabort is a one-cycle strobe and sticky_clr comes from software.
module dbg_sticky_abort (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_mode,
    input  logic in_dbg,
    input  logic dabort,
    input  logic clr,
    output logic sticky,
    output logic dabort_exc
);

    logic set_now;

    // An abort in debug state only counts in halt mode.
    always_comb set_now = dabort && in_dbg && halt_mode;

    // Sticky flag: a new abort wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       sticky <= 1'b0;
        else if (set_now) sticky <= 1'b1;
        else if (clr)     sticky <= 1'b0;
    end

    // Aborts outside debug state go on as a normal exception.
    always_ff @(posedge clk) begin
        if (!rst_n) dabort_exc <= 1'b0;
        else        dabort_exc <= dabort && !in_dbg;
    end

    // R9
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky);

    // R8
    dbg_abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dabort && in_dbg) |=> !dabort_exc);

endmodule

// File: rtl/dbg_vtrap_top.sv
// Module: vector trap unit top. Gates vector hits with the control bits,
// arbitrates them with the other debug events and registers the request.
// Assumes the control inputs come from storage that reset leaves unchanged.
module dbg_vtrap_top
    import dbg_vtrap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_global_en,
    input  logic              cfg_halt_mode,
    input  logic              cfg_high_vec,
    input  logic [N_VEC-1:0]  cfg_trap_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              dabort,
    input  logic              in_dbg_state,
    input  logic              sticky_clr,
    input  logic              evt_ibrk,
    input  logic              evt_dbrk,
    input  logic              evt_tbfull,
    input  logic              evt_ext,
    output logic              dbg_req,
    output logic [2:0]        dbg_cause,
    output logic              sticky_abort,
    output logic              dabort_exc
);

    logic [N_VEC-1:0] vec_hit;
    logic             rst_trap;
    logic             oth_trap;
    logic             any_evt;
    cause_e           cause_nxt;

    dbg_vec_match #(.ADDR_W(ADDR_W), .HIGH_BASE(HIGH_BASE)) u_match (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .high_vec    (cfg_high_vec),
        .hit         (vec_hit)
    );

    // Reset vector trap: no global enable needed.
    always_comb rst_trap = vec_hit[0] && cfg_trap_en[0] && cfg_halt_mode;

    // Other vector traps: every enable must be present.
    always_comb oth_trap = |(vec_hit[N_VEC-1:1] & cfg_trap_en[N_VEC-1:1])
                           && cfg_global_en && cfg_halt_mode;

    dbg_cause_arb u_arb (
        .rst_trap (rst_trap),
        .ibrk     (evt_ibrk),
        .dbrk     (evt_dbrk),
        .vtrap    (oth_trap),
        .tbfull   (evt_tbfull),
        .ext      (evt_ext),
        .any_evt  (any_evt),
        .cause    (cause_nxt)
    );

    // Request register: one pulse per qualifying cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dbg_req <= 1'b0;
        else        dbg_req <= any_evt;
    end

    // Cause register: loads only alongside a request.
    always_ff @(posedge clk) begin
        if (!rst_n)       dbg_cause <= CAUSE_NONE;
        else if (any_evt) dbg_cause <= cause_nxt;
    end

    dbg_sticky_abort u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_mode  (cfg_halt_mode),
        .in_dbg     (in_dbg_state),
        .dabort     (dabort),
        .clr        (sticky_clr),
        .sticky     (sticky_abort),
        .dabort_exc (dabort_exc)
    );

    // R3
    rst_vec_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr == (cfg_high_vec ? HIGH_BASE : '0)
         && cfg_halt_mode && cfg_trap_en[0])
        |=> (dbg_req && dbg_cause == CAUSE_RSTTRAP));

    // R7
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid || evt_ibrk || evt_dbrk || evt_tbfull || evt_ext)
        |=> $stable(dbg_cause));

    // R4
    no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid || evt_ibrk || evt_dbrk || evt_tbfull || evt_ext)
        |=> !dbg_req);

endmodule

// File: tb/dbg_vtrap_top_tb.sv
`timescale 1ns/1ps
module dbg_vtrap_top_tb;

    typedef struct {
        bit         req;
        logic [2:0] cause;
        bit         st;
        bit         dx;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ge, halt, hv;
    logic [6:0]  te;
    logic        fv;
    logic [31:0] addr;
    logic        dab, indbg, clr;
    logic        ib, db, tb, ex;
    logic        dbg_req;
    logic [2:0]  dbg_cause;
    logic        sticky_abort, dabort_exc;

    exp_t        sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;
    bit          m_req, m_st, m_dx;
    logic [2:0]  m_cause;

    always #10 clk = ~clk;

    dbg_vtrap_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_global_en(ge), .cfg_halt_mode(halt),
        .cfg_high_vec(hv), .cfg_trap_en(te), .fetch_valid(fv), .fetch_addr(addr),
        .dabort(dab), .in_dbg_state(indbg), .sticky_clr(clr),
        .evt_ibrk(ib), .evt_dbrk(db), .evt_tbfull(tb), .evt_ext(ex),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause),
        .sticky_abort(sticky_abort), .dabort_exc(dabort_exc)
    );

    // Vector address from the R1 table.
    function automatic logic [31:0] vaddr(input int i, input bit high);
        logic [31:0] b;
        b = high ? 32'hFFFF_0000 : 32'h0;
        case (i)
            0: return b;
            1: return b + 32'h04;
            2: return b + 32'h08;
            3: return b + 32'h0C;
            4: return b + 32'h10;
            5: return b + 32'h18;
            default: return b + 32'h1C;
        endcase
    endfunction

    // Driver: model the expected outputs for the current inputs, then clock.
    task automatic cyc(input string tag);
        exp_t e;
        bit rt, vt;
        if (!rst_n) begin
            m_req = 0; m_cause = 3'd0; m_st = 0; m_dx = 0;
        end else begin
            rt = fv && halt && te[0] && addr == vaddr(0, hv);
            vt = 0;
            for (int i = 1; i < 7; i++)
                if (fv && ge && halt && te[i] && addr == vaddr(i, hv)) vt = 1;
            m_req = rt | ib | db | vt | tb | ex;
            if (rt)      m_cause = 3'd6;
            else if (ib) m_cause = 3'd1;
            else if (db) m_cause = 3'd2;
            else if (vt) m_cause = 3'd3;
            else if (tb) m_cause = 3'd4;
            else if (ex) m_cause = 3'd5;
            m_dx = dab && !indbg;
            if (dab && indbg && halt) m_st = 1;
            else if (clr)             m_st = 0;
        end
        e.req = m_req; e.cause = m_cause; e.st = m_st; e.dx = m_dx; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Drop all strobes back to idle.
    task automatic quiet();
        fv = 0; addr = 32'h0; dab = 0; clr = 0; ib = 0; db = 0; tb = 0; ex = 0;
    endtask

    // Monitor: pop and compare after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_cmp++;
            if (dbg_req !== e.req || dbg_cause !== e.cause ||
                sticky_abort !== e.st || dabort_exc !== e.dx) begin
                n_bad++;
                $display("FAIL %s: got req=%0b cause=%0d st=%0b dx=%0b exp req=%0b cause=%0d st=%0b dx=%0b",
                         e.tag, dbg_req, dbg_cause, sticky_abort, dabort_exc,
                         e.req, e.cause, e.st, e.dx);
            end
        end
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ge = 0; halt = 1; hv = 0; te = 7'b0000001; indbg = 0;
        quiet();
        @(negedge clk);
        // R5: reset-vector fetch during reset is ignored.
        fv = 1; addr = 32'h0;
        cyc("R5 reset");
        cyc("R5 reset");
        cyc("R5 reset");
        rst_n = 1;
        // R3 R5: first reset-vector fetch after reset traps even with ge=0.
        cyc("R3 R5 first fetch");
        quiet();
        // R7: cause holds at 6 while idle.
        cyc("R7 hold");
        // R2: undefined vector without global enable does nothing.
        te = 7'b0000010; fv = 1; addr = 32'h04;
        cyc("R2 no ge");
        ge = 1;
        cyc("R2 armed");
        quiet();
        // R1: each low vector traps when only its own bit is armed.
        for (int i = 1; i < 7; i++) begin
            te = 7'(1 << i); fv = 1; addr = vaddr(i, 0);
            cyc("R1 low vector");
            te = 7'(1 << ((i % 6) + 1)); // wrong bit armed
            cyc("R1 wrong bit");
        end
        te = 7'h7F; fv = 1; addr = 32'h14;
        cyc("R1 reserved slot");
        // R4: valid low blocks the trap.
        fv = 0; addr = 32'h08;
        cyc("R4 no valid");
        // R1: high vector base.
        hv = 1; fv = 1; addr = 32'hFFFF_0018;
        cyc("R1 high irq");
        addr = 32'h18;
        cyc("R1 low addr with high base");
        addr = 32'hFFFF_0000;
        cyc("R1 R3 high reset");
        hv = 0; quiet();
        cyc("R4 one pulse");
        // R6: priority order.
        fv = 1; addr = 32'h0; ib = 1; db = 1; tb = 1; ex = 1;
        cyc("R6 reset top");
        fv = 0;
        cyc("R6 ibrk");
        ib = 0;
        fv = 1; addr = 32'h1C;
        cyc("R6 dbrk over vtrap");
        db = 0;
        cyc("R6 vtrap over tbfull");
        quiet(); tb = 1; ex = 1;
        cyc("R6 tbfull");
        tb = 0;
        cyc("R6 ext");
        quiet();
        // R3: reset trap needs halt mode.
        halt = 0; fv = 1; addr = 32'h0;
        cyc("R3 no halt");
        quiet(); halt = 1;
        // R8: abort in debug state is latched, no exception.
        indbg = 1; dab = 1;
        cyc("R8 latch");
        dab = 0;
        cyc("R9 keep");
        // R10: abort outside debug state is raised.
        indbg = 0; dab = 1;
        cyc("R10 raise");
        dab = 0; clr = 1;
        cyc("R9 clear");
        clr = 0; indbg = 1; halt = 0; dab = 1;
        cyc("R11 no halt");
        halt = 1; clr = 1;
        cyc("R9 set beats clear");
        quiet(); indbg = 0;
        cyc("R9 stays");
        // R5: reset again clears everything.
        rst_n = 0;
        cyc("R5 re-reset");
        rst_n = 1;
        cyc("R7 after reset");
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule